// File: doc/BRIEF.md
# Prescaled Countdown Timer Channel

This block is one down-counting timer channel with a four-word register window. A control word selects which of two tick strobes drives the channel and how far those strobes are divided. The strobes are one-cycle clock enables on the single system clock: one comes from a slow 32768 Hz reference and the other from a fast 24 MHz reference. Every divided tick lowers the current count by one. When the count runs out, the channel sets a pending flag, raises its interrupt output and refills the count from the interval register.

Software sets the interval first. It then writes the control word with the enable bit and, if the new interval should apply at once, the reload bit. Any control write restarts the divider, and the new source and divide ratio take effect from the next cycle. Source codes that name a PLL-derived clock or an invalid source fall back to the fast reference.

Top module: `tmr_chan`

## Requirements
- R1: After reset, offset 0x0 reads 0x00000004 (fast source, divide by 1, disabled). Offsets 0x4, 0x8 and 0xC read 0, and `irq` is low.
- R2: Source field ctrl[3:2]: code 0 selects `slow_stb`, and codes 1, 2 and 3 select `fast_stb`. A strobe on the source that is not selected has no effect on the count.
- R3: Exponent field ctrl[6:4] = n. The count drops by one on every 2^n-th selected strobe, counted from the most recent control write, so a write restarts the division. A 7-bit divider counts the strobes and a decrement happens when its low n bits wrap to zero.
- R4: A control write with bit 1 set loads the interval value into the count in the next cycle. A control write with bit 1 clear leaves the count as it was. No decrement takes place in the cycle of a control write, even if a strobe arrives then.
- R5: A divided tick that finds the count at 1 or 0 sets the pending flag (bit 0 at offset 0xC) and loads the count from the interval register. Any other tick lowers the count by one.
- R6: Writing offset 0xC with bit 0 = 1 clears the pending flag, and writing bit 0 = 0 leaves it set. If an expiry falls in the same cycle as a clearing write, the flag ends up set. `irq` always equals the pending flag.
- R7: While ctrl bit 0 (enable) is 0, the count and the divider hold their values, whatever the strobes do.
- R8: Register map, decoded from `addr[3:0]`: 0x0 control (bits [6:0], upper bits read 0), 0x4 interval (32-bit read/write), 0x8 current count (read-only, writes ignored), 0xC pending. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_stb | input | 1 | One-cycle enable from the 32768 Hz reference |
| fast_stb | input | 1 | One-cycle enable from the 24 MHz reference |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset within the channel |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Pending interrupt flag |

## Verification
Two pairs of events can land in the same cycle. An expiry can coincide with a software write that clears the pending flag. A control write with reload can coincide with a selected strobe. The bench provokes the first by driving `fast_stb` in the same cycle as the clearing write, with the count at 1, and expects the flag to stay set with the count refilled. It provokes the second by pulsing the strobe during the control write, and expects the interval value with no decrement and the divider restarted. A behavioural model advances on every clock, and the bench compares the read-back value and `irq` against it on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int EXP_W   = 3;
    localparam int SRC_W   = 2;
    localparam int CTRL_W  = 1 + 1 + SRC_W + EXP_W;
    localparam int PRE_W   = (1 << EXP_W) - 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_IVAL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 4'hC;

    localparam int BIT_EN     = 0;
    localparam int BIT_RELOAD = 1;
    localparam int SRC_LO     = 2;
    localparam int EXP_LO     = SRC_LO + SRC_W;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 7'h04;

    typedef enum logic [SRC_W-1:0] {
        SRC_SLOW  = 2'd0,
        SRC_FAST  = 2'd1,
        SRC_PLL   = 2'd2,
        SRC_UNDEF = 2'd3
    } src_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [TMR_W-1:0]  interval;
        logic [TMR_W-1:0]  count;
        logic              pending;
    } chan_st_t;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_pkg::*;
(
    input  logic [SRC_W-1:0] src_code,
    input  logic             slow_stb,
    input  logic             fast_stb,
    output logic             sel_stb
);
    always_comb begin
        unique case (src_e'(src_code))
            SRC_SLOW:  sel_stb = slow_stb;
            SRC_FAST:  sel_stb = fast_stb;
            SRC_PLL:   sel_stb = fast_stb;
            SRC_UNDEF: sel_stb = fast_stb;
            default:   sel_stb = fast_stb;
        endcase
    end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int EXP_W = 3,
    localparam int PRE_W = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [EXP_W-1:0] exponent,
    output logic             tick,
    output logic [PRE_W-1:0] pre_cnt
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] pre_inc;
    logic [PRE_W-1:0] mask;

    always_comb begin
        pre_inc = pre_q + PRE_W'(1);
        mask    = ~({PRE_W{1'b1}} << exponent);
        pre_d   = pre_q;
        tick    = 1'b0;
        if (clear) begin
            pre_d = '0;
        end else if (advance) begin
            pre_d = pre_inc;
            tick  = ((pre_inc & mask) == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign pre_cnt = pre_q;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [TMR_W-1:0]  interval,
    input  logic [TMR_W-1:0]  count,
    input  logic              pending,
    output logic [TMR_W-1:0]  rdata
);
    always_comb begin
        unique case (addr)
            OFF_CTRL:  rdata = TMR_W'(ctrl);
            OFF_IVAL:  rdata = interval;
            OFF_COUNT: rdata = count;
            OFF_STAT:  rdata = TMR_W'(pending);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_stb,
    input  logic              fast_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TMR_W-1:0]  wdata,
    output logic [TMR_W-1:0]  rdata,
    output logic              irq
);
    chan_st_t st_d, st_q;

    logic              ctrl_wr, ival_wr, stat_wr;
    logic              sel_stb, advance, tick, expire;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CTRL_W-1:0] ctrl_q;
    logic [TMR_W-1:0]  interval_q, count_q;
    logic              pending_q;

    assign ctrl_q     = st_q.ctrl;
    assign interval_q = st_q.interval;
    assign count_q    = st_q.count;
    assign pending_q  = st_q.pending;

    assign ctrl_wr = wr_en && (addr == OFF_CTRL);
    assign ival_wr = wr_en && (addr == OFF_IVAL);
    assign stat_wr = wr_en && (addr == OFF_STAT);

    tmr_src_sel u_src (
        .src_code (ctrl_q[SRC_LO +: SRC_W]),
        .slow_stb (slow_stb),
        .fast_stb (fast_stb),
        .sel_stb  (sel_stb)
    );

    assign advance = ctrl_q[BIT_EN] && sel_stb && !ctrl_wr;

    tmr_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctrl_wr),
        .advance  (advance),
        .exponent (ctrl_q[EXP_LO +: EXP_W]),
        .tick     (tick),
        .pre_cnt  (pre_cnt)
    );

    assign expire = tick && (count_q <= TMR_W'(1));

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            if (wdata[BIT_RELOAD]) st_d.count = st_q.interval;
        end else if (tick) begin
            st_d.count = expire ? st_q.interval : st_q.count - TMR_W'(1);
        end
        if (ival_wr) st_d.interval = wdata;
        if (stat_wr && wdata[0]) st_d.pending = 1'b0;
        if (expire) st_d.pending = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl     <= CTRL_RESET;
            st_q.interval <= '0;
            st_q.count    <= '0;
            st_q.pending  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    tmr_rd_mux u_rd (
        .addr     (addr),
        .ctrl     (ctrl_q),
        .interval (interval_q),
        .count    (count_q),
        .pending  (pending_q),
        .rdata    (rdata)
    );

    assign irq = pending_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              slow_stb,
    input logic              fast_stb,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [TMR_W-1:0]  wdata,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [TMR_W-1:0]  interval_q,
    input logic [TMR_W-1:0]  count_q,
    input logic              pending_q,
    input logic [PRE_W-1:0]  pre_cnt
);
    logic cw;
    assign cw = wr_en && (addr == OFF_CTRL);

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_stb && !fast_stb && !cw) |=> $stable(count_q)); // R2

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (pre_cnt == '0)); // R3

    AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wdata[BIT_RELOAD]) |=> (count_q == $past(interval_q))); // R4

    AST_EXPIRY_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_q) |-> (count_q == $past(interval_q))); // R5

    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !(wr_en && addr == OFF_STAT && wdata[0])) |=> pending_q); // R6

    AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[BIT_EN] && !cw) |=> ($stable(count_q) && $stable(pre_cnt))); // R7
endmodule

bind tmr_chan tmr_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_stb   (slow_stb),
    .fast_stb   (fast_stb),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .ctrl_q     (ctrl_q),
    .interval_q (interval_q),
    .count_q    (count_q),
    .pending_q  (pending_q),
    .pre_cnt    (pre_cnt)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_stb = 1'b0, fast_stb = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = 4'h8;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural reference state
    int unsigned m_ctrl = 4, m_pre = 0, m_pend = 0;
    logic [31:0] m_ival = 0, m_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_chan u_dut (
        .clk(clk), .rst_n(rst_n), .slow_stb(slow_stb), .fast_stb(fast_stb),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h0:    return 32'(m_ctrl);
            4'h4:    return m_ival;
            4'h8:    return m_cnt;
            4'hC:    return 32'(m_pend);
            default: return 32'd0;
        endcase
    endfunction

    // reference model advanced on every edge, compared a quarter period later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 4; m_pre = 0; m_pend = 0; m_ival = 0; m_cnt = 0;
        end else begin
            bit cwr, sel, tk, ex;
            int unsigned n;
            cwr = wr_en && addr == 4'h0;
            n = (m_ctrl >> 4) & 7;
            sel = (((m_ctrl >> 2) & 3) == 0) ? slow_stb : fast_stb;
            tk = 0;
            if (cwr) m_pre = 0;
            else if ((m_ctrl & 1) && sel) begin
                m_pre = (m_pre + 1) % 128;
                tk = (m_pre % (1 << n)) == 0;
            end
            ex = tk && (m_cnt <= 1);
            if (cwr) begin
                if (wdata[1]) m_cnt = m_ival;
            end else if (tk) m_cnt = ex ? m_ival : m_cnt - 1;
            if (cwr) m_ctrl = wdata & 32'h7f;
            if (wr_en && addr == 4'h4) m_ival = wdata;
            if (wr_en && addr == 4'hC && wdata[0]) m_pend = 0;
            if (ex) m_pend = 1;
        end
        #(CLK_P/4);
        if (rst_n && !done) begin
            total++;
            if (rdata !== m_read(addr)) begin
                bad++;
                $display("FAIL R8 model read addr=%h actual=%h expected=%h", addr, rdata, m_read(addr));
            end
            total++;
            if (irq !== m_pend[0]) begin
                bad++;
                $display("FAIL R6 model irq actual=%0b expected=%0d", irq, m_pend);
            end
        end
    end

    task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d,
                        input bit f, input bit s);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; fast_stb = f; slow_stb = s;
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        step(0, a, 0, 0, 0);
        @(posedge clk);
        #(CLK_P/4);
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        step(0, 4'h8, 0, 0, 0);
        @(posedge clk);
        #(CLK_P/4);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    // k selected strobes, each followed by a strobe on the other source
    task automatic pulses(input bit use_slow, input int k);
        for (int i = 0; i < k; i++) begin
            step(0, 4'h8, 0, !use_slow, use_slow);
            step(0, 4'h8, 0, use_slow, !use_slow);
        end
        step(0, 4'h8, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(4'h0, 32'h4, "R1 ctrl reset");
        chk_rd(4'h4, 0, "R1 interval reset");
        chk_rd(4'h8, 0, "R1 count reset");
        chk_rd(4'hC, 0, "R1 pending reset");
        chk_irq(0, "R1 irq reset");

        // R8 count is read-only, unused offsets inert
        step(1, 4'h8, 32'd55, 0, 0);
        chk_rd(4'h8, 0, "R8 count write ignored");
        step(1, 4'h1, 32'hFFFF_FFFF, 0, 0);
        chk_rd(4'h1, 0, "R8 unused offset");
        chk_rd(4'h0, 32'h4, "R8 ctrl untouched by unused write");

        // R2 / R3 decrement spacing for every source code and exponent
        for (int src = 0; src < 4; src++) begin
            for (int n = 0; n < 8; n++) begin
                step(1, 4'h4, 32'd1000, 0, 0);
                step(1, 4'h0, 32'((n << 4) | (src << 2) | 3), 0, 0);
                pulses(src == 0, 3 << n);
                chk_rd(4'h8, 32'd997, $sformatf("R2 R3 src=%0d n=%0d", src, n));
            end
        end

        // R7 disabled channel holds; R4 write without reload keeps count
        step(1, 4'h4, 32'd1000, 0, 0);
        step(1, 4'h0, 32'h06, 0, 0);
        pulses(0, 5);
        chk_rd(4'h8, 32'd1000, "R7 disabled hold");
        step(1, 4'h0, 32'h05, 0, 0);
        chk_rd(4'h8, 32'd1000, "R4 no reload keeps count");
        pulses(0, 2);
        chk_rd(4'h8, 32'd998, "R7 enabled decrements");

        // R5 expiry
        step(1, 4'h4, 32'd3, 0, 0);
        step(1, 4'h0, 32'h07, 0, 0);
        pulses(0, 3);
        chk_irq(1, "R5 expiry sets pending");
        chk_rd(4'h8, 32'd3, "R5 refill on expiry");

        // R6 clear semantics and collision with expiry
        step(1, 4'hC, 32'd0, 0, 0);
        chk_rd(4'hC, 1, "R6 write 0 keeps pending");
        step(1, 4'hC, 32'd1, 0, 0);
        chk_rd(4'hC, 0, "R6 write 1 clears");
        pulses(0, 2);
        chk_rd(4'h8, 32'd1, "R5 count at one");
        step(1, 4'hC, 32'd1, 1, 0);
        chk_irq(1, "R6 expiry wins over clear");
        chk_rd(4'h8, 32'd3, "R6 refill during clear");
        step(1, 4'hC, 32'd1, 0, 0);

        // R4 reload write coinciding with strobe
        step(1, 4'h4, 32'd9, 0, 0);
        step(1, 4'h0, 32'h07, 1, 0);
        chk_rd(4'h8, 32'd9, "R4 reload beats strobe");

        // R3 divider restart on control write
        step(1, 4'h4, 32'd100, 0, 0);
        step(1, 4'h0, 32'h27, 0, 0);
        pulses(0, 3);
        step(1, 4'h0, 32'h25, 0, 0);
        pulses(0, 3);
        chk_rd(4'h8, 32'd100, "R3 restart delays tick");
        pulses(0, 1);
        chk_rd(4'h8, 32'd99, "R3 tick after restart");

        step(0, 4'h8, 0, 0, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule